// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Signal-Loss Clamp

This block sits behind a clock-and-data recovery stage. It takes a retimed serial bit stream, one bit per clock cycle when a bit-valid strobe is high, and packs it into 10-bit words. The bit received first in each word is placed on bit 0 of the parallel output. A one-cycle word-valid strobe marks each new word.

When alignment is enabled, the block looks for the 7-bit prefix of a positive-disparity comma. In arrival order this prefix is 0,0,1,1,1,1,1. When the block finds it, it moves the word boundary so that the comma begins a word. The boundary only ever moves later. The bits of the word that was being built are dropped, and the gap between word strobes grows. It never shrinks. The word that carries the comma is flagged on a comma indicator output.

The framer works on the stream six valid bits behind the newest bit. It therefore knows that a comma is present before it has to commit the word that holds the comma's first bit. A loss-of-signal input forces the parallel output to all ones. Framing continues underneath, so normal words return as soon as the signal does.

Top module: `comma_deser`

## Requirements
- R1: With no comma accepted, a word is emitted for every 10 valid bits. Arrival bit k of the word (k = 0 is the earliest) is on word_out[k]. word_vld is high for exactly one cycle per word.
- R2: Cycles with bit_vld low are ignored: they neither add a bit nor advance framing, and bit_in has no effect in those cycles.
- R3: A comma is the arrival sequence 0,0,1,1,1,1,1 on word bits 0 to 6, that is, word_out[6:0] = 7'b1111100. Bits 7 to 9 are don't-care. A comma is recognised only if align_en is 1 in the cycle that accepts its seventh bit.
- R4: When a recognised comma starts anywhere other than the current word boundary, the partial word is dropped. The comma word is emitted with the comma's first bit on word_out[0], and the gap between strobes is longer than 10 valid bits, never shorter.
- R5: When a recognised comma already starts at the word boundary, framing is unchanged and the strobe spacing stays at 10 valid bits.
- R6: After a realignment, a further comma that begins before the realigned comma word has been emitted is ignored.
- R7: comma_seen is high only in the word_vld cycle of a word that begins with a recognised comma. It stays low for any comma seen while align_en is 0.
- R8: In every cycle that follows a cycle with los_in = 1, word_out is 10'b1111111111. A word emitted while los_in is 1 carries all ones, and comma_seen stays low for it.
- R9: After reset, word_out is all ones and word_vld and comma_seen are 0. The first word holds six fill ones on bits 0 to 5, followed by the first four stream bits.
- R10: A word whose last bit is stream bit n is presented in the cycle after the clock edge that accepts stream bit n+6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | bit_in holds a new serial bit this cycle |
| bit_in | input | 1 | Retimed serial data bit |
| align_en | input | 1 | Enables comma recognition and realignment |
| los_in | input | 1 | Loss of signal; clamps the output to all ones |
| word_out | output | 10 | Parallel word, earliest received bit on bit 0 |
| word_vld | output | 1 | One-cycle strobe for a new word |
| comma_seen | output | 1 | The word now on word_out begins with a recognised comma |

## Verification
Some properties are checked by assertions on every cycle:
- the strobe is a single-cycle pulse;
- at least ten valid bits separate strobes, and a stall never yields a strobe;
- comma_seen appears only together with word_vld and a comma prefix on word_out[6:0];
- the output is all ones after any cycle with loss of signal.

Other behaviour can only be shown by the bench's scenarios against the stream it generated:
- where each boundary lands after a realignment;
- that the comma word carries the right data;
- that a disabled or second comma leaves framing alone;
- that every offset from 0 to 9 between a comma and the old boundary is handled.

// File: rtl/comma_deser_pkg.sv
// Shared constants for the comma-aligning deserializer.
// Assumes: arrival bit i of a pattern is stored at vector index i.
package comma_deser_pkg;
    localparam int          CD_WORD_W = 10;
    localparam int          CD_PFX_W  = 7;
    // Arrival order 0,0,1,1,1,1,1 -> index 0 holds the first bit.
    localparam logic [6:0]  CD_PFX_PAT = 7'b1111100;
endpackage

// File: rtl/comma_pfx_det.sv
// Prefix detector with a short look-ahead delay line.
// Keeps the last PFX_W-1 valid bits. Flags a match when the newest
// PFX_W bits equal PAT and hands the oldest stored bit to the framer,
// so the framer trails the input by PFX_W-1 valid bits.
// Assumes: the reset fill of ones cannot match (PAT bit 0 is zero).
module comma_pfx_det #(
    parameter int               PFX_W = 7,
    parameter logic [PFX_W-1:0] PAT   = 7'b1111100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic frm_bit,
    output logic pfx_hit
);
    localparam int DL = PFX_W - 1;

    logic [DL-1:0]    dline;
    logic [PFX_W-1:0] window;

    // Newest bit on top, oldest stored bit at index 0.
    always_comb begin
        window  = {bit_in, dline};
        pfx_hit = bit_vld && (window == PAT);
        frm_bit = dline[0];
    end

    // Shift the delay line on every valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dline <= '1;
        end else if (bit_vld) begin
            dline <= {bit_in, dline[DL-1:1]};
        end
    end
endmodule

// File: rtl/word_framer.sv
// Word framer: packs delayed bits into words and applies comma realignment.
// A recognised comma at a nonzero count drops the partial word and starts
// a new one (stretch only). Commas are ignored while a stretched word is
// still open.
// Assumes: frm_bit/pfx_hit are qualified by the same bit_vld.
module word_framer #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              frm_bit,
    input  logic              pfx_hit,
    input  logic              align_en,
    output logic              emit,
    output logic [WORD_W-1:0] word_nxt,
    output logic              comma_word
);
    localparam int CW = $clog2(WORD_W);
    localparam int GW = CW + 2;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);
    localparam logic [GW-1:0] GAP_MAX  = '1;

    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] shreg;
    logic              stretched;
    logic              pend;
    logic              take;
    logic              realign;
    logic              last;
    logic [GW-1:0]     gap;

    // Decide acceptance, realignment and word completion for this bit.
    always_comb begin
        take     = pfx_hit && align_en && !stretched;
        realign  = take && (cnt != '0);
        last     = bit_vld && (cnt == LAST_IDX) && !realign;
        word_nxt = {frm_bit, shreg[WORD_W-1:1]};
        emit     = last;
        comma_word = pend;
    end

    // Bit shifter and position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
        end else if (bit_vld) begin
            shreg <= word_nxt;
            if (realign)   cnt <= CW'(1);
            else if (last) cnt <= '0;
            else           cnt <= cnt + CW'(1);
        end
    end

    // Stretch guard and pending comma marker for the open word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stretched <= 1'b0;
            pend      <= 1'b0;
        end else if (bit_vld) begin
            if (realign)   stretched <= 1'b1;
            else if (last) stretched <= 1'b0;
            if (take)      pend <= 1'b1;
            else if (last) pend <= 1'b0;
        end
    end

    // Independent count of valid bits since the last emitted word.
    always_ff @(posedge clk) begin
        if (!rst_n)                        gap <= '0;
        else if (emit)                     gap <= '0;
        else if (bit_vld && gap != GAP_MAX) gap <= gap + GW'(1);
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> (gap >= GW'(WORD_W - 1))) else $error("short word"); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_IDX) else $error("count out of range"); // R1
    AST_STRETCH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (stretched && emit) |=> !stretched) else $error("stretch stuck"); // R6
endmodule

// File: rtl/word_out_stage.sv
// Output register stage: holds the last word, clamps to all ones on
// loss of signal and produces the strobe and comma flag.
// Assumes: emit is a single-cycle pulse from the framer.
module word_out_stage #(
    parameter int               WORD_W = 10,
    parameter int               PFX_W  = 7,
    parameter logic [PFX_W-1:0] PAT    = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic [WORD_W-1:0] word_nxt,
    input  logic              comma_word,
    input  logic              los_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              comma_seen
);
    // Data register with loss-of-signal clamp.
    always_ff @(posedge clk) begin
        if (!rst_n)      word_out <= '1;
        else if (los_in) word_out <= '1;
        else if (emit)   word_out <= word_nxt;
    end

    // Strobe and comma flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld   <= 1'b0;
            comma_seen <= 1'b0;
        end else begin
            word_vld   <= emit;
            comma_seen <= emit && comma_word && !los_in;
        end
    end

    AST_LOS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        los_in |=> (word_out == '1)) else $error("no clamp"); // R8
    AST_SEEN_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        comma_seen |-> word_vld) else $error("flag without word"); // R7
    AST_SEEN_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        comma_seen |-> (word_out[PFX_W-1:0] == PAT)) else $error("flag on non-comma"); // R3
endmodule

// File: rtl/comma_deser.sv
// Top: comma-aligning deserializer with loss-of-signal clamp.
// Chain: prefix detector (look-ahead) -> word framer -> output stage.
// Assumes: one serial bit per cycle at most, qualified by bit_vld;
// commas are not sent in back-to-back words.
module comma_deser
    import comma_deser_pkg::*;
#(
    parameter int                  WORD_W = CD_WORD_W,
    parameter int                  PFX_W  = CD_PFX_W,
    parameter logic [PFX_W-1:0]    PAT    = CD_PFX_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic              align_en,
    input  logic              los_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              comma_seen
);
    logic              frm_bit;
    logic              pfx_hit;
    logic              emit;
    logic [WORD_W-1:0] word_nxt;
    logic              comma_word;

    comma_pfx_det #(.PFX_W(PFX_W), .PAT(PAT)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .frm_bit (frm_bit),
        .pfx_hit (pfx_hit)
    );

    word_framer #(.WORD_W(WORD_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld    (bit_vld),
        .frm_bit    (frm_bit),
        .pfx_hit    (pfx_hit),
        .align_en   (align_en),
        .emit       (emit),
        .word_nxt   (word_nxt),
        .comma_word (comma_word)
    );

    word_out_stage #(.WORD_W(WORD_W), .PFX_W(PFX_W), .PAT(PAT)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .emit       (emit),
        .word_nxt   (word_nxt),
        .comma_word (comma_word),
        .los_in     (los_in),
        .word_out   (word_out),
        .word_vld   (word_vld),
        .comma_seen (comma_seen)
    );

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld) else $error("strobe too long"); // R1
    AST_STALL_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !word_vld) else $error("word on stall"); // R2
endmodule

// File: tb/tb_comma_deser.sv
// Bench: drives a generated stream with commas at chosen offsets, stalls,
// an enable-off window and a loss-of-signal window. Expected boundaries
// come from the comma positions by the stretch rule.
module tb_comma_deser;
    localparam int N  = 580;
    localparam int NC = 18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic       align_en = 1'b1;
    logic       los_in = 1'b0;
    logic [9:0] word_out;
    logic       word_vld;
    logic       comma_seen;

    int  n_chk = 0;
    int  n_bad = 0;
    int  sent = 0;
    int  exp_prev = -7;
    bit  los_prev = 1'b0;
    bit  done = 1'b0;
    logic strm  [0:N-1];
    bit   en_at [0:N-1];
    bit   los_at[0:N-1];
    int   cpos  [0:NC-1];

    always #2 clk = ~clk;

    comma_deser dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .align_en(align_en), .los_in(los_in),
        .word_out(word_out), .word_vld(word_vld), .comma_seen(comma_seen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic put_comma(input int c, input logic [2:0] tail);
        logic [9:0] k;
        k = {tail[0], tail[1], tail[2], 7'b1111100};
        for (int i = 0; i < 10; i++) strm[c+i] = k[i];
    endtask

    // Stretch rule: earliest enabled comma after prev that begins within
    // the next ten bits becomes the next word; otherwise a ten-bit step.
    function automatic int next_end(input int prev, output bit flag);
        int best;
        best = N + 100;
        for (int i = 0; i < NC; i++)
            if (cpos[i] > prev && cpos[i] < best && en_at[cpos[i] + 6])
                best = cpos[i];
        if (best <= prev + 10) begin
            flag = 1'b1;
            return best + 9;
        end
        flag = 1'b0;
        return prev + 10;
    endfunction

    function automatic logic [9:0] slice(input int j);
        logic [9:0] w;
        for (int n = 0; n < 10; n++)
            w[n] = (j - 9 + n < 0) ? 1'b1 : strm[j - 9 + n];
        return w;
    endfunction

    task automatic observe();
        int  j, ej;
        bit  ef;
        logic [9:0] ew;
        if (los_prev) chk(word_out == 10'h3ff, "R8 clamp", word_out, 10'h3ff);
        if (!word_vld) begin
            chk(!comma_seen, "R7 flag without word", comma_seen, 0);
            return;
        end
        j  = sent - 7;
        ej = next_end(exp_prev, ef);
        chk(j == ej, "R4/R5/R6/R10 word end", j, ej);
        ew = los_at[j + 6] ? 10'h3ff : slice(j);
        if (j < 9) chk(word_out == ew, "R9 first word", word_out, ew);
        else       chk(word_out == ew, "R1 word data", word_out, ew);
        chk(comma_seen == (ef && !los_at[j + 6]), "R7 comma flag",
            comma_seen, ef && !los_at[j + 6]);
        exp_prev = ej;
    endtask

    task automatic step(input bit v, input logic b);
        @(negedge clk);
        observe();
        los_prev = los_in;
        bit_vld  = v;
        bit_in   = b;
        if (v) begin
            en_at[sent]  = align_en;
            los_at[sent] = los_in;
            sent++;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", sent, N);
        finish_up();
    end

    initial begin
        int ej;
        bit ef;
        for (int i = 0; i < N; i++) begin
            strm[i] = logic'(i % 2);
            en_at[i] = 1'b1;
            los_at[i] = 1'b0;
        end
        cpos[0] = 40;  cpos[1] = 60;  cpos[2] = 103; cpos[3] = 110;
        cpos[4] = 150; cpos[5] = 200; cpos[6] = 240;
        cpos[7] = 300;
        for (int k = 1; k <= 10; k++) cpos[7 + k] = cpos[6 + k] + 20 + (k - 1);
        for (int i = 0; i < NC; i++) put_comma(cpos[i], 3'b010);
        put_comma(103, 3'b001);   // tail opens the second comma at 110
        put_comma(110, 3'b010);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_out == 10'h3ff, "R9 reset word", word_out, 10'h3ff);
        chk(!word_vld, "R9 reset strobe", word_vld, 0);
        chk(!comma_seen, "R9 reset flag", comma_seen, 0);

        for (int k = 0; k < N; k++) begin
            align_en = !(k >= 140 && k <= 170);   // R3 disabled window
            los_in   = (k >= 230 && k <= 260);    // R8 window
            if (k % 7 == 3) step(1'b0, ~strm[k]); // R2 stall, junk bit
            step(1'b1, strm[k]);
        end
        bit_vld = 1'b0;
        los_in  = 1'b0;
        repeat (3) step(1'b0, 1'b1);
        ej = next_end(exp_prev, ef);
        chk(ej + 6 > N - 1, "R1 missing word", ej, N);
        finish_up();
    end
endmodule